// File: doc/BRIEF.md
# 8-bit ALU with Flags

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor datapath. From a 4-bit operation code, two 8-bit operands and the current carry and auxiliary-carry flags, it produces an 8-bit result. It also produces new values for the carry (C), auxiliary carry (AC), zero (Z) and overflow (OV) flags, together with a mask that says which of those flags the operation updates. Holding the flags in a register and sequencing instructions are left to the surrounding datapath.

Subtraction follows a "carry means no borrow" convention. After a subtract, C = 1 means the minuend was at least the subtrahend. AC uses the same rule at the 4-bit boundary. Two skip outputs report whether the result is zero or non-zero, so a sequencer can make skip-style branch decisions without decoding the result itself.

Top module: `alu8_flags`

## Requirements
- R1: Opcode 0 (ADD) gives a+b and opcode 1 (ADC) gives a+b+c_in, each modulo 256. C is the carry out of bit 7.
- R2: Opcode 2 (SUB) gives a-b and opcode 3 (SBC) gives a-b-(1-c_in), each modulo 256. C is 1 exactly when no borrow out of bit 7 occurs.
- R3: For opcodes 0 to 3, AC is the carry out of bit 3 on add and the absence of a borrow into bit 4 on subtract.
- R4: For opcodes 0 to 3, OV is 1 exactly when the carry into bit 7 differs from the carry out of bit 7, which is signed overflow.
- R5: Z equals 1 exactly when the 8-bit result is zero, for every opcode whose mask includes Z.
- R6: Opcodes 5 (AND), 6 (OR) and 7 (XOR) combine a with b bitwise, and opcode 8 (CPL) gives ~a. These four opcodes update only Z (mask 4'b0100).
- R7: Opcode 9 (RL) rotates a left by one bit and opcode 10 (RR) rotates it right by one bit. Both update no flag. Opcode 11 (RLC) gives {a[6:0], c_in} with C = a[7]. Opcode 12 (RRC) gives {c_in, a[7:1]} with C = a[0]. Both update only C.
- R8: Opcode 13 (INC) gives a+1 and opcode 14 (DEC) gives a-1, each wrapping modulo 256. Both update only Z.
- R9: Opcode 4 (DAA) adds 06h when a[3:0] > 9 or ac_in is 1. It then adds 60h when the partly adjusted value has a high nibble above 9, carried out of bit 7, or c_in is 1. C is 1 exactly when the 60h step was applied. Only C is updated.
- R10: upd_mask has bit 0 for C, bit 1 for AC, bit 2 for Z and bit 3 for OV. It is 4'b1111 for opcodes 0 to 3. Each flag output whose mask bit is 0 is driven to 0.
- R11: Opcode 15 is reserved. It passes a through unchanged and updates no flag.
- R12: skip_zero is 1 exactly when the result is zero, and skip_nonzero is its complement, for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a | input | 8 | First operand; the only operand of unary operations |
| b | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| result | output | 8 | Operation result |
| c_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| z_out | output | 1 | New zero flag |
| ov_out | output | 1 | New overflow flag |
| upd_mask | output | 4 | Flags updated by this operation {OV, Z, AC, C} |
| skip_zero | output | 1 | Result is zero |
| skip_nonzero | output | 1 | Result is non-zero |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with no register stage between input and output. The driver applies one operation just after a rising edge and pushes the expected outputs into the scoreboard queue. The monitor takes each item off at the following falling edge, once the inputs have been stable for half a period, so every comparison sees the outputs of the operation that was queued with it. Hand-picked corner cases are followed by a long pseudo-random sweep over all opcodes, checked against a flag model written in the bench.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Holds the shared data width, the operation codes and the bit positions of
// the flag update mask. Assumes an 8-bit datapath with 4-bit nibbles.
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int FLAGS = 4;

    localparam int F_C  = 0;
    localparam int F_AC = 1;
    localparam int F_Z  = 2;
    localparam int F_OV = 3;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_DAA  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_RL   = 4'd9,
        OP_RR   = 4'd10,
        OP_RLC  = 4'd11,
        OP_RRC  = 4'd12,
        OP_INC  = 4'd13,
        OP_DEC  = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
// Module alu8_addsub
// Shared binary adder for add, subtract, increment and decrement. A subtract
// inverts the second operand; the caller supplies the carry input, so that
// carry out = 1 means "no borrow". Assumes W is even (nibble boundary W/2).
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_cout,
    output logic         ovf
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic [H:0]   lo_sum;
    logic [W-1:0] up_low;
    logic [W:0]   full;

    // Select true or inverted second operand.
    always_comb b_eff = invert_b ? ~opb : opb;

    // Form the sum, the nibble carry and the carry into the top bit.
    always_comb begin
        lo_sum    = {1'b0, opa[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
        up_low    = {1'b0, opa[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin};
        full      = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum       = full[W-1:0];
        cout      = full[W];
        half_cout = lo_sum[H];
        ovf       = up_low[W-1] ^ full[W];
    end
endmodule

// File: rtl/alu8_decadj.sv
// Module alu8_decadj
// Decimal adjust of an accumulator after a BCD addition. Adds 06h for a low
// digit above 9 or a set nibble carry, then 60h for a high digit above 9,
// a carry out of the first step or a set carry. Assumes an 8-bit value.
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DW-1:0] val,
    input  logic          cy,
    input  logic          acy,
    output logic [DW-1:0] adj,
    output logic          dcy
);
    logic          lo_fix;
    logic          hi_fix;
    logic [DW:0]   step1;

    // Apply the two correction steps in order.
    always_comb begin
        lo_fix = (val[NW-1:0] > 4'd9) || acy;
        step1  = {1'b0, val} + (lo_fix ? 9'h006 : 9'h000);
        hi_fix = (step1[DW-1:NW] > 4'd9) || step1[DW] || cy;
        adj    = step1[DW-1:0] + (hi_fix ? 8'h60 : 8'h00);
        dcy    = hi_fix;
    end
endmodule

// File: rtl/alu8_logicrot.sv
// Module alu8_logicrot
// Bitwise logic, complement and the four single-bit rotates. The carry output
// is only meaningful for the two rotate-through-carry operations.
module alu8_logicrot
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          cy,
    output logic [DW-1:0] res,
    output logic          rcy
);
    // Pick the logic or rotate result for the current operation.
    always_comb begin
        res = opa;
        rcy = 1'b0;
        unique case (op)
            OP_AND: res = opa & opb;
            OP_OR:  res = opa | opb;
            OP_XOR: res = opa ^ opb;
            OP_CPL: res = ~opa;
            OP_RL:  res = {opa[DW-2:0], opa[DW-1]};
            OP_RR:  res = {opa[0], opa[DW-1:1]};
            OP_RLC: begin
                res = {opa[DW-2:0], cy};
                rcy = opa[DW-1];
            end
            OP_RRC: begin
                res = {cy, opa[DW-1:1]};
                rcy = opa[0];
            end
            default: res = opa;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
// Module alu8_flags (top)
// Combinational 8-bit ALU. Routes the operation to the shared adder, the
// decimal adjuster or the logic/rotate unit, and produces the flags, the
// flag update mask and the zero/non-zero skip conditions. Assumes the caller
// holds the flags and applies only those selected by upd_mask.
module alu8_flags
    import alu8_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_in,
    input  logic          ac_in,
    output logic [DW-1:0] result,
    output logic          c_out,
    output logic          ac_out,
    output logic          z_out,
    output logic          ov_out,
    output logic [FLAGS-1:0] upd_mask,
    output logic          skip_zero,
    output logic          skip_nonzero
);
    alu_op_e       opc;
    logic [DW-1:0] add_b;
    logic          add_inv;
    logic          add_cin;
    logic [DW-1:0] add_sum;
    logic          add_cy;
    logic          add_hcy;
    logic          add_ov;
    logic [DW-1:0] daa_res;
    logic          daa_cy;
    logic [DW-1:0] lr_res;
    logic          lr_cy;
    logic          res_zero;

    // Decode the operation code.
    always_comb opc = alu_op_e'(op);

    // Set up the adder operands for the arithmetic operations.
    always_comb begin
        add_b   = b;
        add_inv = 1'b0;
        add_cin = 1'b0;
        unique case (opc)
            OP_ADC: add_cin = c_in;
            OP_SUB: begin add_inv = 1'b1; add_cin = 1'b1; end
            OP_SBC: begin add_inv = 1'b1; add_cin = c_in; end
            OP_INC: begin add_b = '0; add_cin = 1'b1; end
            OP_DEC: begin add_b = {{(DW-1){1'b0}}, 1'b1}; add_inv = 1'b1; add_cin = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(DW)) u_addsub (
        .opa       (a),
        .opb       (add_b),
        .invert_b  (add_inv),
        .cin       (add_cin),
        .sum       (add_sum),
        .cout      (add_cy),
        .half_cout (add_hcy),
        .ovf       (add_ov)
    );

    alu8_decadj u_decadj (
        .val (a),
        .cy  (c_in),
        .acy (ac_in),
        .adj (daa_res),
        .dcy (daa_cy)
    );

    alu8_logicrot u_logicrot (
        .op  (opc),
        .opa (a),
        .opb (b),
        .cy  (c_in),
        .res (lr_res),
        .rcy (lr_cy)
    );

    // Select the result and the set of flags this operation updates.
    always_comb begin
        unique case (opc)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result   = add_sum;
                upd_mask = 4'b1111;
            end
            OP_INC, OP_DEC: begin
                result   = add_sum;
                upd_mask = 4'b0100;
            end
            OP_DAA: begin
                result   = daa_res;
                upd_mask = 4'b0001;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                result   = lr_res;
                upd_mask = 4'b0100;
            end
            OP_RLC, OP_RRC: begin
                result   = lr_res;
                upd_mask = 4'b0001;
            end
            OP_RL, OP_RR: begin
                result   = lr_res;
                upd_mask = 4'b0000;
            end
            default: begin
                result   = a;
                upd_mask = 4'b0000;
            end
        endcase
    end

    // Produce flag values, zeroed where the mask does not select them.
    always_comb begin
        res_zero = (result == '0);
        c_out    = 1'b0;
        if (upd_mask[F_C]) begin
            if (opc == OP_DAA)                       c_out = daa_cy;
            else if (opc == OP_RLC || opc == OP_RRC) c_out = lr_cy;
            else                                     c_out = add_cy;
        end
        ac_out = upd_mask[F_AC] & add_hcy;
        ov_out = upd_mask[F_OV] & add_ov;
        z_out  = upd_mask[F_Z]  & res_zero;
    end

    // Skip conditions for zero-test branch decisions.
    always_comb begin
        skip_zero    = res_zero;
        skip_nonzero = ~res_zero;
    end
endmodule

// File: rtl/alu8_flags_chk.sv
// Module alu8_flags_chk
// Checker for alu8_flags, bound to every instance. The block is purely
// combinational, so the checks are immediate assertions on settled values.
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic [3:0]       op,
    input logic [DW-1:0]    a,
    input logic [DW-1:0]    result,
    input logic             c_out,
    input logic             ac_out,
    input logic             z_out,
    input logic             ov_out,
    input logic [FLAGS-1:0] upd_mask,
    input logic             skip_zero,
    input logic             skip_nonzero
);
    // Check skip, mask and flag relations whenever the inputs are known.
    always_comb begin
        if (!$isunknown({op, a})) begin
            p_skip_excl_r12: assert (skip_zero != skip_nonzero)
                else $error("skip outputs not complementary");
            p_skip_result_r12: assert (skip_zero == (result == '0))
                else $error("skip_zero disagrees with result");
            p_zero_flag_r5: assert (!upd_mask[F_Z] || (z_out == skip_zero))
                else $error("Z disagrees with zero result");
            p_masked_zero_r10: assert (((~upd_mask) & {ov_out, z_out, ac_out, c_out}) == '0)
                else $error("flag set outside update mask");
            p_arith_mask_r10: assert ((op > 4'd3) || (upd_mask == 4'b1111))
                else $error("arithmetic op does not update all flags");
            p_reserved_pass_r11: assert ((op != 4'd15) || ((result == a) && (upd_mask == '0)))
                else $error("reserved op not a pass-through");
        end
    end
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .op           (op),
    .a            (a),
    .result       (result),
    .c_out        (c_out),
    .ac_out       (ac_out),
    .z_out        (z_out),
    .ov_out       (ov_out),
    .upd_mask     (upd_mask),
    .skip_zero    (skip_zero),
    .skip_nonzero (skip_nonzero)
);

// File: tb/tb_alu8_flags.sv
// Scoreboard bench for alu8_flags: a driver queues expected outputs from an
// independent model, a monitor compares them at the following falling edge.
module tb_alu8_flags;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] res;
        logic [3:0] flg;   // {OV, Z, AC, C}
        logic [3:0] msk;
        logic       skz;
        logic       sknz;
        logic [7:0] tag;   // requirement number
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] a = 8'd0;
    logic [7:0] b = 8'd0;
    logic       c_in = 1'b0;
    logic       ac_in = 1'b0;
    logic [7:0] result;
    logic       c_out, ac_out, z_out, ov_out, skip_zero, skip_nonzero;
    logic [3:0] upd_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    alu8_flags dut (
        .op(op), .a(a), .b(b), .c_in(c_in), .ac_in(ac_in),
        .result(result), .c_out(c_out), .ac_out(ac_out), .z_out(z_out),
        .ov_out(ov_out), .upd_mask(upd_mask),
        .skip_zero(skip_zero), .skip_nonzero(skip_nonzero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Independent model of the requirements.
    function automatic exp_t model(input logic [3:0] o, input logic [7:0] x,
                                   input logic [7:0] y, input logic ci,
                                   input logic aci, input logic [7:0] t);
        exp_t e;
        int s, lo, va;
        logic c, ac, ov;
        e = '0; e.op = o; e.tag = t; c = 0; ac = 0; ov = 0;
        case (o)
            0, 1: begin   // R1 R3 R4
                s  = x + y + ((o == 1) ? ci : 0);
                lo = x[3:0] + y[3:0] + ((o == 1) ? ci : 0);
                e.res = s[7:0]; c = (s > 255); ac = (lo > 15);
                ov = (x[7] == y[7]) && (e.res[7] != x[7]);
                e.msk = 4'b1111;
            end
            2, 3: begin   // R2 R3 R4
                s  = x - y - ((o == 3) ? (1 - ci) : 0);
                lo = x[3:0] - y[3:0] - ((o == 3) ? (1 - ci) : 0);
                e.res = s[7:0]; c = (s >= 0); ac = (lo >= 0);
                ov = (x[7] != y[7]) && (e.res[7] != x[7]);
                e.msk = 4'b1111;
            end
            4: begin      // R9
                va = x;
                if (x[3:0] > 9 || aci) va = va + 6;
                c = (((va >> 4) & 15) > 9) || (va > 255) || ci;
                if (c) va = va + 96;
                e.res = va[7:0]; e.msk = 4'b0001;
            end
            5: begin e.res = x & y; e.msk = 4'b0100; end
            6: begin e.res = x | y; e.msk = 4'b0100; end
            7: begin e.res = x ^ y; e.msk = 4'b0100; end
            8: begin e.res = ~x;    e.msk = 4'b0100; end
            9:  e.res = {x[6:0], x[7]};
            10: e.res = {x[0], x[7:1]};
            11: begin e.res = {x[6:0], ci}; c = x[7]; e.msk = 4'b0001; end
            12: begin e.res = {ci, x[7:1]}; c = x[0]; e.msk = 4'b0001; end
            13: begin e.res = x + 8'd1; e.msk = 4'b0100; end
            14: begin e.res = x - 8'd1; e.msk = 4'b0100; end
            default: e.res = x;
        endcase
        e.skz  = (e.res == 0);
        e.sknz = (e.res != 0);
        e.flg  = {ov, e.skz, ac, c} & e.msk;
        return e;
    endfunction

    // Driver: apply one operation after a rising edge and queue its expectation.
    task automatic drive(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                         input logic ci, input logic aci, input logic [7:0] t);
        @(posedge clk);
        #1;
        op = o; a = x; b = y; c_in = ci; ac_in = aci;
        sb.push_back(model(o, x, y, ci, aci, t));
    endtask

    // Monitor: outputs are due in the same cycle; compare at the falling edge.
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            logic [3:0] got;
            e = sb.pop_front();
            got = {ov_out, z_out, ac_out, c_out};
            checks++;
            if (result !== e.res || got !== e.flg || upd_mask !== e.msk ||
                skip_zero !== e.skz || skip_nonzero !== e.sknz) begin
                errors++;
                $display("FAIL R%0d op=%0d res=%h/%h flags=%b/%b mask=%b/%b skip=%b%b/%b%b (actual/expected)",
                         e.tag, e.op, result, e.res, got, e.flg, upd_mask, e.msk,
                         skip_zero, skip_nonzero, e.skz, e.sknz);
            end
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero inputs give ADD 0+0 -> 0, Z and C/AC/OV clear (R5)
        drive(4'd0, 8'h00, 8'h00, 0, 0, 8'd5);
        // R1
        drive(4'd0, 8'hFF, 8'h01, 0, 0, 8'd1);
        drive(4'd1, 8'h10, 8'h20, 1, 0, 8'd1);
        // R4 signed overflow on add and subtract
        drive(4'd0, 8'h7F, 8'h01, 0, 0, 8'd4);
        drive(4'd2, 8'h80, 8'h01, 0, 0, 8'd4);
        // R2 borrow / no borrow, R3 nibble borrow
        drive(4'd2, 8'h05, 8'h03, 0, 0, 8'd2);
        drive(4'd2, 8'h03, 8'h05, 0, 0, 8'd2);
        drive(4'd3, 8'h05, 8'h03, 0, 0, 8'd2);
        drive(4'd3, 8'h05, 8'h05, 1, 0, 8'd2);
        drive(4'd2, 8'h10, 8'h01, 0, 0, 8'd3);
        drive(4'd0, 8'h0F, 8'h01, 0, 0, 8'd3);
        // R9 decimal adjust
        drive(4'd4, 8'h9A, 8'h00, 0, 0, 8'd9);
        drive(4'd4, 8'h15, 8'h00, 0, 1, 8'd9);
        drive(4'd4, 8'h12, 8'h00, 1, 0, 8'd9);
        drive(4'd4, 8'h45, 8'h00, 0, 0, 8'd9);
        // R6 logic, carry input ignored
        drive(4'd5, 8'hF0, 8'h0F, 1, 1, 8'd6);
        drive(4'd6, 8'hA0, 8'h05, 1, 0, 8'd6);
        drive(4'd7, 8'h5A, 8'h5A, 0, 1, 8'd6);
        drive(4'd8, 8'hFF, 8'h00, 1, 0, 8'd6);
        // R7 rotates
        drive(4'd9,  8'h81, 8'h00, 0, 0, 8'd7);
        drive(4'd10, 8'h01, 8'h00, 1, 1, 8'd7);
        drive(4'd11, 8'h80, 8'h00, 0, 0, 8'd7);
        drive(4'd11, 8'h00, 8'h00, 1, 0, 8'd7);
        drive(4'd12, 8'h01, 8'h00, 0, 0, 8'd7);
        drive(4'd12, 8'h00, 8'h00, 1, 0, 8'd7);
        // R8 wrap
        drive(4'd13, 8'hFF, 8'h00, 0, 0, 8'd8);
        drive(4'd14, 8'h00, 8'h00, 1, 0, 8'd8);
        drive(4'd14, 8'h01, 8'h00, 0, 0, 8'd8);
        // R11 reserved, R12 skip on non-zero
        drive(4'd15, 8'h00, 8'hFF, 1, 1, 8'd11);
        drive(4'd15, 8'h3C, 8'hFF, 1, 1, 8'd12);
        // R10 sweep: mask and all flags over every opcode
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf[3:0], lf[11:4], {lf[7:0] ^ lf[15:8]}, lf[12], lf[14], 8'd10);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int n;
        n = 0;
        while (!done && n < WATCHDOG) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R0 watchdog expired actual=%0d expected<%0d cycles", n, WATCHDOG);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule